// File: doc/BRIEF.md
# Burst-Four Quad-Rate SRAM Controller

This block sits between a user request port and a synchronous SRAM with separate read and write data buses and a fixed burst of four words. It turns each accepted request into a command with its address. For a write it also launches the four data beats with their byte enables. For a read it gathers the four returned beats into one response. Reads and writes share the command slot on alternate clock cycles, so a read stream and a write stream can run at full rate at the same time.

The block uses one clock. Each clock period stands for one K period of the memory. Every data bus is split into a K-edge half (`_k`) and a K#-edge half (`_kn`), which model the two captures that happen in that period. A burst is 144 bits wide: four beats of 36 bits each. Beat i sits at bits [36*i +: 36]. Each beat has four 9-bit lanes, and lane j of a beat sits at [9*j +: 9]. Byte enables are 16 bits wide and active high: bit 4*i+j enables lane j of beat i.

Top module: `qdr4_ctrl`

## Requirements
- R1: While `rst` is high, `sram_rd`, `sram_wr` and `resp_valid` are 0, the write enable halves are 0, and `req_ready` is 1 for a read request.
- R2: Counting cycles from the first cycle after reset release as cycle 0, `req_ready` is 1 for reads only in even cycles and for writes only in odd cycles.
- R3: A request accepted (`req_valid` and `req_ready` high) in cycle a drives `sram_rd` (read) or `sram_wr` (write) high in cycle a+1, with `sram_addr` equal to the request address.
- R4: `sram_rd` and `sram_wr` are never high together, and neither is high in two consecutive cycles.
- R5: For a write command in cycle w, beat 0 and beat 1 appear on `sram_wd_k`/`sram_wd_kn` in cycle w+1, and beat 2 and beat 3 appear in cycle w+2. In every other cycle both enable halves are 0.
- R6: Each enable bit travels with its beat and lane. A lane whose bit is 0 leaves that memory lane unchanged, and a lane whose bit is 1 replaces it.
- R7: For a read command in cycle r, beat 0 is taken from `sram_rq_kn` in cycle r+2. Beat 1 and beat 2 are taken from `sram_rq_k` and `sram_rq_kn` in cycle r+3. Beat 3 is taken from `sram_rq_k` in cycle r+4.
- R8: `resp_valid` is high for exactly one cycle, r+5, with all four beats packed in order in `resp_rdata`. This is six cycles after the read was accepted.
- R9: A request that is not accepted issues no command: `sram_rd` and `sram_wr` stay 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory K period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Burst address |
| req_wdata | input | 144 | Four write beats |
| req_be | input | 16 | Per-beat, per-lane write enables |
| req_ready | output | 1 | Slot for this request type is free |
| resp_valid | output | 1 | Read burst complete |
| resp_rdata | output | 144 | Four read beats in order |
| sram_addr | output | 19 | Command address |
| sram_rd | output | 1 | Read command |
| sram_wr | output | 1 | Write command |
| sram_wd_k | output | 36 | Write beat for the K capture |
| sram_wbe_k | output | 4 | Lane enables for the K beat |
| sram_wd_kn | output | 36 | Write beat for the K# capture |
| sram_wbe_kn | output | 4 | Lane enables for the K# beat |
| sram_rq_k | input | 36 | Read beat launched at K |
| sram_rq_kn | input | 36 | Read beat launched at K# |

## Verification
The assertions assume that `req_wdata` is stable during the cycle a write is accepted, and that the `req_ready` seen by the requester is evaluated with the final value of `req_write`. The bench drives every request field at the falling edge and holds it until the next one, so both assumptions hold. A memory model in the bench returns each read burst on the exact K/K# timing of R7. It captures the memory word when the read command is seen. The stimulus never reads an address within four cycles of a write to that address, so the captured word is always the fully written one.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
    parameter int LANE_W  = 9;
    parameter int LANES   = 4;
    parameter int BEATS   = 4;
    parameter int ADDR_W  = 19;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int BURST_W = WORD_W * BEATS;
    localparam int BE_W    = LANES * BEATS;
    // read pipeline depth: command to last beat capture
    localparam int RD_STAGES = 4;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LANES-1:0]   lane_en_t;
    typedef logic [BURST_W-1:0] burst_t;
    typedef logic [BE_W-1:0]    burst_en_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic word_t beat_of(input burst_t b, input int idx);
        return b[idx*WORD_W +: WORD_W];
    endfunction

    function automatic lane_en_t en_of(input burst_en_t e, input int idx);
        return e[idx*LANES +: LANES];
    endfunction
endpackage

// File: rtl/qdr4_sched.sv
module qdr4_sched
    import qdr4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              wr_accept,
    output cmd_t              cmd
);
    // slot phase: 0 = read slot, 1 = write slot
    logic phase;
    logic accept;

    assign req_ready = req_write ? phase : ~phase;
    assign accept    = req_valid & req_ready;
    assign wr_accept = accept & req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            cmd   <= '0;
        end else begin
            phase    <= ~phase;
            cmd.rd   <= accept & ~req_write;
            cmd.wr   <= accept & req_write;
            cmd.addr <= accept ? req_addr : '0;
        end
    end
endmodule

// File: rtl/qdr4_wr_launch.sv
module qdr4_wr_launch
    import qdr4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  burst_t    wdata,
    input  burst_en_t wen,
    input  logic      start,
    output word_t     wd_k,
    output lane_en_t  wbe_k,
    output word_t     wd_kn,
    output lane_en_t  wbe_kn
);
    burst_t    pend_d;
    burst_en_t pend_e;
    logic      second;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_d <= '0;
            pend_e <= '0;
        end else if (load) begin
            pend_d <= wdata;
            pend_e <= wen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            second <= 1'b0;
            wd_k   <= '0;
            wbe_k  <= '0;
            wd_kn  <= '0;
            wbe_kn <= '0;
        end else if (start) begin
            second <= 1'b1;
            wd_k   <= beat_of(pend_d, 0);
            wbe_k  <= en_of(pend_e, 0);
            wd_kn  <= beat_of(pend_d, 1);
            wbe_kn <= en_of(pend_e, 1);
        end else if (second) begin
            second <= 1'b0;
            wd_k   <= beat_of(pend_d, 2);
            wbe_k  <= en_of(pend_e, 2);
            wd_kn  <= beat_of(pend_d, 3);
            wbe_kn <= en_of(pend_e, 3);
        end else begin
            wd_k   <= '0;
            wbe_k  <= '0;
            wd_kn  <= '0;
            wbe_kn <= '0;
        end
    end
endmodule

// File: rtl/qdr4_rd_gather.sv
module qdr4_rd_gather
    import qdr4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  word_t  rq_k,
    input  word_t  rq_kn,
    output logic   resp_valid,
    output burst_t resp_rdata
);
    logic [RD_STAGES-1:0] pipe;
    word_t b0, b1, b2;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[RD_STAGES-2:0], start};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b0 <= '0;
            b1 <= '0;
            b2 <= '0;
        end else begin
            if (pipe[1]) b0 <= rq_kn;
            if (pipe[2]) begin
                b1 <= rq_k;
                b2 <= rq_kn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= pipe[3];
            if (pipe[3]) resp_rdata <= {rq_k, b2, b1, b0};
        end
    end
endmodule

// File: rtl/qdr4_ctrl.sv
module qdr4_ctrl
    import qdr4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BURST_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [BURST_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_rd,
    output logic              sram_wr,
    output logic [WORD_W-1:0] sram_wd_k,
    output logic [LANES-1:0]  sram_wbe_k,
    output logic [WORD_W-1:0] sram_wd_kn,
    output logic [LANES-1:0]  sram_wbe_kn,
    input  logic [WORD_W-1:0] sram_rq_k,
    input  logic [WORD_W-1:0] sram_rq_kn
);
    cmd_t cmd;
    logic wr_accept;

    qdr4_sched u_sched (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .wr_accept (wr_accept),
        .cmd       (cmd)
    );

    assign sram_rd   = cmd.rd;
    assign sram_wr   = cmd.wr;
    assign sram_addr = cmd.addr;

    qdr4_wr_launch u_wr (
        .clk    (clk),
        .rst    (rst),
        .load   (wr_accept),
        .wdata  (req_wdata),
        .wen    (req_be),
        .start  (cmd.wr),
        .wd_k   (sram_wd_k),
        .wbe_k  (sram_wbe_k),
        .wd_kn  (sram_wd_kn),
        .wbe_kn (sram_wbe_kn)
    );

    qdr4_rd_gather u_rd (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd.rd),
        .rq_k       (sram_rq_k),
        .rq_kn      (sram_rq_kn),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata)
    );
endmodule

// File: rtl/qdr4_ctrl_chk.sv
module qdr4_ctrl_chk
    import qdr4_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [BURST_W-1:0] req_wdata,
    input logic               sram_rd,
    input logic               sram_wr,
    input logic [ADDR_W-1:0]  sram_addr,
    input logic [WORD_W-1:0]  sram_wd_k,
    input logic [WORD_W-1:0]  sram_wd_kn,
    input logic               resp_valid
);
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sram_rd && sram_wr));

    a_r4_rd_spacing: assert property (@(posedge clk) disable iff (rst)
        sram_rd |=> !sram_rd);

    a_r4_wr_spacing: assert property (@(posedge clk) disable iff (rst)
        sram_wr |=> !sram_wr);

    a_r3_rd_cmd: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> (sram_rd && sram_addr == $past(req_addr)));

    a_r3_wr_cmd: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (sram_wr && sram_addr == $past(req_addr)));

    a_r9_no_cmd: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> (!sram_rd && !sram_wr));

    a_r5_first_beats: assert property (@(posedge clk) disable iff (rst)
        sram_wr |=> (sram_wd_k == $past(req_wdata[WORD_W-1:0], 2)
                     && sram_wd_kn == $past(req_wdata[2*WORD_W-1:WORD_W], 2)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
endmodule

bind qdr4_ctrl qdr4_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sram_rd    (sram_rd),
    .sram_wr    (sram_wr),
    .sram_addr  (sram_addr),
    .sram_wd_k  (sram_wd_k),
    .sram_wd_kn (sram_wd_kn),
    .resp_valid (resp_valid)
);

// File: tb/qdr4_ctrl_tb.sv
module qdr4_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [18:0]  req_addr = '0;
    logic [143:0] req_wdata = '0;
    logic [15:0]  req_be = '0;
    logic         req_ready, resp_valid, sram_rd, sram_wr;
    logic [143:0] resp_rdata;
    logic [18:0]  sram_addr;
    logic [35:0]  sram_wd_k, sram_wd_kn;
    logic [3:0]   sram_wbe_k, sram_wbe_kn;
    logic [35:0]  sram_rq_k = '0, sram_rq_kn = '0;

    qdr4_ctrl u_dut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    logic [143:0] mem [16];
    logic [143:0] refm [16];
    int           lastw [16];
    logic [143:0] exp_d [$];
    int           exp_c [$];
    logic [35:0]  sch_k [8];
    logic [35:0]  sch_kn [8];
    localparam logic [35:0] JUNK = 36'h9DEADBEEF;

    task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [35:0] m36(input logic [35:0] o, input logic [35:0] n, input logic [3:0] e);
        logic [35:0] r = o;
        for (int l = 0; l < 4; l++) if (e[l]) r[9*l +: 9] = n[9*l +: 9];
        return r;
    endfunction

    function automatic logic [143:0] m144(input logic [143:0] o, input logic [143:0] n, input logic [15:0] e);
        logic [143:0] r;
        for (int b = 0; b < 4; b++) r[36*b +: 36] = m36(o[36*b +: 36], n[36*b +: 36], e[4*b +: 4]);
        return r;
    endfunction

    // memory model: R5/R6 write capture, R7 read launch timing
    int          wcnt = 0;
    logic [3:0]  wa;
    always @(negedge clk) begin
        if (!rst) begin
            if (wcnt == 2) begin
                mem[wa][35:0]  = m36(mem[wa][35:0],  sram_wd_k,  sram_wbe_k);
                mem[wa][71:36] = m36(mem[wa][71:36], sram_wd_kn, sram_wbe_kn);
                wcnt = 1;
            end else if (wcnt == 1) begin
                mem[wa][107:72]  = m36(mem[wa][107:72],  sram_wd_k,  sram_wbe_k);
                mem[wa][143:108] = m36(mem[wa][143:108], sram_wd_kn, sram_wbe_kn);
                wcnt = 0;
            end else begin
                chk(sram_wbe_k == 0 && sram_wbe_kn == 0, "R5 idle enables",
                    {sram_wbe_k, sram_wbe_kn}, 0);
            end
            if (sram_wr) begin
                wa = sram_addr[3:0];
                wcnt = 2;
            end
            if (sram_rd) begin
                logic [143:0] s;
                s = mem[sram_addr[3:0]];
                sch_kn[(cyc + 2) % 8] = s[35:0];
                sch_k [(cyc + 3) % 8] = s[71:36];
                sch_kn[(cyc + 3) % 8] = s[107:72];
                sch_k [(cyc + 4) % 8] = s[143:108];
            end
            sram_rq_k  = sch_k[cyc % 8];
            sram_rq_kn = sch_kn[cyc % 8];
            sch_k[cyc % 8]  = JUNK;
            sch_kn[cyc % 8] = ~JUNK;
        end
    end

    // response checker: R8 timing and data, R6/R7 content
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_d.size() == 0) begin
                chk(1'b0, "R8 unexpected response", resp_rdata, 0);
            end else begin
                logic [143:0] d;
                int c;
                d = exp_d.pop_front();
                c = exp_c.pop_front();
                chk(cyc == c, "R8 response cycle", cyc, c);
                chk(resp_rdata == d, "R6/R7/R8 read data", resp_rdata, d);
            end
        end
    end

    // one request cycle: drive at falling edge, check R2, then R3/R9 one cycle later
    task automatic step(input bit v, input bit w, input logic [18:0] a,
                        input logic [143:0] d, input logic [15:0] e);
        bit acc;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = e;
        #1;
        chk(req_ready == (w ? cyc[0] : ~cyc[0]), "R2 slot ready", req_ready, w ? cyc[0] : ~cyc[0]);
        acc = v && req_ready;
        if (acc) begin
            if (w) begin
                refm[a[3:0]] = m144(refm[a[3:0]], d, e);
                lastw[a[3:0]] = cyc;
            end else begin
                exp_d.push_back(refm[a[3:0]]);
                exp_c.push_back(cyc + 6);
            end
        end
        @(negedge clk);
        if (acc)
            chk(sram_rd == !w && sram_wr == w && sram_addr == a, "R3 command",
                {sram_rd, sram_wr, sram_addr}, {!w, w, a});
        else
            chk(!sram_rd && !sram_wr, "R9 no command", {sram_rd, sram_wr}, 0);
    endtask

    function automatic logic [143:0] rnd144();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            mem[i]  = {4{i[8:0] * 9'd37, 9'h0F0, 9'h155, i[8:0]}};
            refm[i] = mem[i];
            lastw[i] = -100;
        end
        for (int i = 0; i < 8; i++) begin sch_k[i] = JUNK; sch_kn[i] = ~JUNK; end
        repeat (3) @(negedge clk);
        // R1 reset state
        #1;
        chk(!sram_rd && !sram_wr && !resp_valid, "R1 reset commands", {sram_rd, sram_wr, resp_valid}, 0);
        chk(sram_wbe_k == 0 && sram_wbe_kn == 0, "R1 reset enables", {sram_wbe_k, sram_wbe_kn}, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        @(negedge clk);
        rst = 1'b0;
        // directed corners
        step(1, 0, 19'd3, '0, '0);                    // c0 read, accepted
        step(1, 0, 19'd4, '0, '0);                    // c1 read in write slot: R9
        step(1, 1, 19'd5, rnd144(), 16'hFFFF);        // c2 write in read slot: R9
        step(1, 1, 19'd5, rnd144(), 16'hFFFF);        // c3 full write
        step(0, 0, '0, '0, '0);
        step(1, 1, 19'd6, rnd144(), 16'hA5C3);        // c5 partial lanes, R6
        step(0, 0, '0, '0, '0);
        step(0, 0, '0, '0, '0);
        step(1, 0, 19'd5, '0, '0);                    // c8 read back full write
        step(0, 0, '0, '0, '0);
        step(1, 0, 19'd6, '0, '0);                    // c10 read back masked write
        step(1, 1, 19'd7, rnd144(), 16'h0000);        // c11 all lanes masked, R6
        for (int k = 0; k < 6; k++) step(0, 0, '0, '0, '0);
        step(1, 0, 19'd7, '0, '0);                    // c18 unchanged word
        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit v, w;
            logic [18:0] a;
            v = ($urandom() % 8) != 0;
            w = $urandom() % 2;
            a = 19'($urandom() % 16);
            if (!w && (cyc - lastw[a[3:0]]) < 5) w = 1'b1;
            step(v, w, a, rnd144(), 16'($urandom()));
        end
        for (int k = 0; k < 10; k++) step(0, 0, '0, '0, '0);
        chk(exp_d.size() == 0, "R8 all responses returned", exp_d.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule